// File: doc/BRIEF.md
# Replayable FIFO with Active-Low Status Flags

This block is a single-clock first-in first-out buffer for 9-bit words. Its depth is a power of two set by a parameter. Words written with the write enable leave on the read port in the order they arrived. Every read that the buffer accepts produces a word one cycle later, together with a valid indication. When no word is being delivered, the output bus is treated as undriven and sits at zero.

Three active-low flags report the fill level: empty, half-full and full. All three are derived from the distance between a read pointer and a write pointer, each one bit wider than the address. A read while empty is refused, and so is a write while full; a refused operation leaves its pointer where it was. An active-low master reset puts both pointers at location zero.

An active-low retransmit input rewinds the read side to location zero, so the words stored from location zero up to the write position can be delivered again, for example to resend a packet or to repeat a pattern. Retransmit is accepted at any fill level. A write in the same cycle still completes. A read in the same cycle is dropped, so the rewind always takes effect.

Top module: `fifo_rt`

## Requirements
- R1: While master reset is low and after it is released, empty is low, half-full and full are high, and the valid output is low.
- R2: An accepted read makes the valid output high in the next cycle, and the data output then carries the oldest unread word. Words leave in write order.
- R3: A read while empty is refused: the valid output stays low and the read pointer does not move. This holds even when a write is accepted in the same cycle.
- R4: A write while full is refused: the word is discarded and the write pointer does not move. This holds even when a read is accepted in the same cycle.
- R5: Empty is low exactly when the occupancy (write pointer minus read pointer, modulo twice the depth) is zero.
- R6: Full is low exactly when the occupancy equals the depth.
- R7: Half-full is low exactly when the occupancy is at least half the depth.
- R8: Whenever the valid output is low, the data output is all zeros.
- R9: Retransmit low sets the read address to zero. The new occupancy is the write address, meaning the write pointer's low address bits after any write in the same cycle.
- R10: If that write address is zero while the buffer holds data (counting a write in the same cycle), the rewind leaves the buffer full. A full buffer whose write address is zero therefore stays full.
- R11: A write in the same cycle as a retransmit is accepted under the normal full rule and is delivered in order during the replay.
- R12: A read in the same cycle as a retransmit is ignored: the valid output is low in the next cycle and the rewind takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| mrN | input | 1 | Master reset, active low, asynchronous |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request |
| rtN | input | 1 | Retransmit (rewind read side), active low |
| rdData | output | DATA_W | Delivered word, zero when not valid |
| rdValid | output | 1 | Output-enable indication for rdData |
| emptyN | output | 1 | Empty flag, active low |
| halfN | output | 1 | Half-full flag, active low |
| fullN | output | 1 | Full flag, active low |

## Verification
The bench builds the block with 9-bit words and a 4-bit address, which gives a depth of 16. At that depth, filling the buffer, crossing the half-full point and wrapping the pointers each take only a few dozen cycles. The same setting makes it quick to land the write address on zero with data held, the one case where a rewind must leave the buffer full. A reference model computed from the requirements checks every cycle of directed and random traffic. In that traffic, retransmit collides with reads and with writes at many fill levels.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

  // Strobes from control to datapath: one accepted operation each.
  typedef struct packed {
    logic wrStrobe;
    logic rdStrobe;
  } fifoStrobes_t;

endpackage

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              mrN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              rtN,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyN,
  output logic              halfN,
  output logic              fullN
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_LVL = PTR_W'(DEPTH / 2);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W-1:0] wrPtrNext, rdPtrNext;
  logic [PTR_W-1:0] fill;
  logic isEmpty, isFull, isHalf;
  logic wrGo, rdGo, rewind, wrapFlip;

  // Occupancy from the pointer distance; the extra bit separates full from empty.
  assign fill    = wrPtr - rdPtr;
  assign isEmpty = (fill == '0);
  assign isFull  = (fill == FULL_LVL);
  assign isHalf  = (fill >= HALF_LVL);

  assign rewind = ~rtN;
  assign wrGo   = wrEn & ~isFull;
  // Retransmit wins over a read so the read pointer has one source per cycle.
  assign rdGo   = rdEn & ~isEmpty & ~rewind;

  assign wrPtrNext = wrPtr + PTR_W'(wrGo);

  // On rewind, keep the replay window non-empty when data is held at a zero write address.
  assign wrapFlip = (wrPtrNext[ADDR_W-1:0] == '0) & (~isEmpty | wrGo);

  always_comb begin
    if (rewind) begin
      rdPtrNext = {wrPtrNext[ADDR_W] ^ wrapFlip, {ADDR_W{1'b0}}};
    end else begin
      rdPtrNext = rdPtr + PTR_W'(rdGo);
    end
  end

  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrPtrNext;
      rdPtr <= rdPtrNext;
    end
  end

  assign strobes.wrStrobe = wrGo;
  assign strobes.rdStrobe = rdGo;
  assign wrAddr = wrPtr[ADDR_W-1:0];
  assign rdAddr = rdPtr[ADDR_W-1:0];

  assign emptyN = ~isEmpty;
  assign halfN  = ~isHalf;
  assign fullN  = ~isFull;

endmodule

// File: rtl/fifo_rt_dp.sv
module fifo_rt_dp
  import fifo_rt_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              mrN,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // One register row per location, each loaded on its own decoded strobe.
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic rowLoad;
    assign rowLoad = strobes.wrStrobe & (wrAddr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (rowLoad) store[i] <= wrData;
    end
  end

  // Registered output; the bus reads zero when no word is delivered.
  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdStrobe;
      rdData  <= strobes.rdStrobe ? store[rdAddr] : '0;
    end
  end

endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              mrN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rtN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              emptyN,
  output logic              halfN,
  output logic              fullN
);

  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_rt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .mrN(mrN), .wrEn(wrEn), .rdEn(rdEn), .rtN(rtN),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .halfN(halfN), .fullN(fullN)
  );

  fifo_rt_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .mrN(mrN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/fifo_rt_checker.sv
module fifo_rt_checker #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              mrN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              rtN,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              emptyN,
  input logic              halfN,
  input logic              fullN
);

  a_r5_not_empty_and_full: assert property (@(posedge clk) disable iff (!mrN)
    !(!emptyN && !fullN));

  a_r7_full_implies_half: assert property (@(posedge clk) disable iff (!mrN)
    !fullN |-> !halfN);

  a_r8_idle_bus_zero: assert property (@(posedge clk) disable iff (!mrN)
    !rdValid |-> (rdData == '0));

  a_r12_rewind_drops_read: assert property (@(posedge clk) disable iff (!mrN)
    !rtN |=> !rdValid);

  a_r3_empty_read_refused: assert property (@(posedge clk) disable iff (!mrN)
    !emptyN |=> !rdValid);

  a_r4_full_write_refused: assert property (@(posedge clk) disable iff (!mrN)
    (!fullN && rtN && !rdEn) |=> !fullN);

  a_r5_empty_holds: assert property (@(posedge clk) disable iff (!mrN)
    (!emptyN && rtN && !wrEn) |=> !emptyN);

  a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (!mrN)
    rdValid |-> $past(rdEn));

  a_r1_reset_state: assert property (@(posedge clk)
    !mrN |-> (!emptyN && halfN && fullN && !rdValid));

endmodule

bind fifo_rt fifo_rt_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .mrN(mrN), .wrEn(wrEn), .rdEn(rdEn), .rtN(rtN),
  .rdData(rdData), .rdValid(rdValid),
  .emptyN(emptyN), .halfN(halfN), .fullN(fullN)
);

// File: tb/fifo_rt_bench.sv
module fifo_rt_bench;

  localparam int DW    = 9;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          mrN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0, rtN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          rdValid, emptyN, halfN, fullN;

  fifo_rt #(.DATA_W(DW), .ADDR_W(AW)) u_fifo_rt (
    .clk(clk), .mrN(mrN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rtN(rtN),
    .rdData(rdData), .rdValid(rdValid), .emptyN(emptyN), .halfN(halfN), .fullN(fullN)
  );

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  // Reference model built from the requirements.
  logic [DW-1:0] model [DEPTH];
  logic [AW:0]   mWp = '0, mRp = '0;
  bit            lastGot;
  logic [DW-1:0] lastWord;

  task automatic chk(bit ok, string tag, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fillOf();
    logic [AW:0] d;
    d = mWp - mRp;
    return int'(d);
  endfunction

  task automatic step(bit w, logic [DW-1:0] d, bit r, bit rt);
    int f, f2;
    bit wAcc, rAcc, flip;
    logic [AW:0]   nw;
    logic [DW-1:0] expData;
    wrEn = w; wrData = d; rdEn = r; rtN = !rt;
    f = fillOf();
    wAcc = w && (f < DEPTH);
    rAcc = r && (f > 0) && !rt;
    expData = rAcc ? model[mRp[AW-1:0]] : '0;
    if (wAcc) model[mWp[AW-1:0]] = d;
    nw = mWp + (AW+1)'(wAcc);
    if (rt) begin
      flip = (nw[AW-1:0] == '0) && ((f > 0) || wAcc);
      mRp = {nw[AW] ^ flip, {AW{1'b0}}};
    end else begin
      mRp = mRp + (AW+1)'(rAcc);
    end
    mWp = nw;
    @(posedge clk);
    #2;
    f2 = fillOf();
    chk(rdValid == rAcc, "R2 valid", int'(rdValid), int'(rAcc));
    chk(rdData == expData, rAcc ? "R2 data" : "R8 idle bus", int'(rdData), int'(expData));
    chk(emptyN == (f2 != 0), "R5 empty", int'(emptyN), int'(f2 != 0));
    chk(fullN == (f2 != DEPTH), "R6 full", int'(fullN), int'(f2 != DEPTH));
    chk(halfN == (f2 < DEPTH/2), "R7 half", int'(halfN), int'(f2 < DEPTH/2));
    lastGot = rdValid;
    lastWord = rdData;
    wrEn = 0; rdEn = 0; rtN = 1;
  endtask

  task automatic doReset();
    @(negedge clk);
    mrN = 0; wrEn = 0; rdEn = 0; rtN = 1;
    mWp = '0; mRp = '0;
    @(negedge clk);
    chk(!emptyN && halfN && fullN && !rdValid, "R1 reset flags",
        int'({emptyN, halfN, fullN, rdValid}), 6);
    mrN = 1;
    @(negedge clk);
    chk(!emptyN && halfN && fullN && !rdValid, "R1 after release",
        int'({emptyN, halfN, fullN, rdValid}), 6);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    doReset();

    // R3: read while empty, then with a write in the same cycle
    step(0, '0, 1, 0);
    chk(!lastGot, "R3 empty read", int'(lastGot), 0);
    step(1, 9'h1A5, 1, 0);
    chk(!lastGot, "R3 read with first write", int'(lastGot), 0);
    step(0, '0, 1, 0);
    chk(lastGot && lastWord == 9'h1A5, "R3 pointer unmoved", int'(lastWord), 9'h1A5);

    // Fill to full, then a refused write (R4), then drain in order (R2)
    for (int i = 0; i < DEPTH; i++) step(1, DW'(i * 7 + 3), 0, 0);
    chk(!fullN, "R6 full after depth writes", int'(fullN), 0);
    step(1, 9'h0FF, 1, 0);
    chk(lastGot && lastWord == DW'(3), "R4 read beside refused write", int'(lastWord), 3);
    for (int i = 1; i < DEPTH; i++) begin
      step(0, '0, 1, 0);
      chk(lastWord == DW'(i * 7 + 3), "R2 order", int'(lastWord), i * 7 + 3);
    end
    chk(!emptyN, "R4 discarded word absent", int'(emptyN), 0);

    // R9: rewind mid-stream; location zero holds the word at fill index 15
    for (int i = 0; i < 4; i++) step(1, DW'(9'h100 + i), 0, 0);
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    step(0, '0, 0, 1);
    step(0, '0, 1, 0);
    chk(lastWord == DW'(15 * 7 + 3), "R9 replay from zero", int'(lastWord), 15 * 7 + 3);

    // R12: read with retransmit is dropped
    step(0, '0, 1, 1);
    chk(!lastGot, "R12 read dropped", int'(lastGot), 0);

    // R11: write during retransmit is replayed last
    step(1, 9'h155, 0, 1);
    while (emptyN) step(0, '0, 1, 0);
    chk(lastWord == 9'h155, "R11 concurrent write kept", int'(lastWord), 9'h155);

    // R10: write address back at zero with data held -> rewind gives full
    doReset();
    for (int i = 0; i < DEPTH; i++) step(1, DW'(9'h40 + i), 0, 0);
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 1);
    chk(!fullN, "R10 rewind to full", int'(fullN), 0);
    step(0, '0, 0, 1);
    chk(!fullN, "R10 full stays full", int'(fullN), 0);
    step(0, '0, 1, 0);
    chk(lastWord == DW'(9'h40), "R10 first replay word", int'(lastWord), 9'h40);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      bit w, r, rt;
      w  = ($urandom % 100) < 55;
      r  = ($urandom % 100) < 50;
      rt = ($urandom % 25) == 0;
      step(w, DW'($urandom), r, rt);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule